// File: doc/BRIEF.md
# Card Presence and Readiness Status Controller

This block drives the single active-low status line that a smart card interface shares with its host. Outside a card session the line tells the host whether a card sits in the slot and whether the interface is ready to start a session. Inside a session the same line signals a fault. The block also raises a deactivation request whenever a session fault occurs.

The block enters and leaves a low-power state using only the three existing host control inputs: activate (active low), card reset and voltage select. After waking, it holds the status line low while the oscillator warms up. Presence is debounced asymmetrically. An insertion must stay stable for a number of millisecond ticks. A removal is reported at once and is then held for a minimum time. All host, presence, supply and fault inputs are asynchronous and pass through two-flop synchronizers. Time is measured with a one-cycle millisecond enable tick. The status output is a pull-down enable for an open-drain line whose pull-up lies outside the block.

Top module: `card_status_ctrl`

## Requirements
- R1: After reset `status_pd` is 1 and `pwr_down`, `act_permit` and `deact_req` are 0. Outside a session, `status_pd` is 1 whenever the debounced card state is absent.
- R2: After `card_pres` rises, the card is reported present (`status_pd` falls outside a session) only on the 5th `ms_tick` during which presence has stayed high. Any low level restarts the count.
- R3: When `card_pres` falls, `status_pd` is 1 on the third rising clock edge after the change. The card is then not reported present again until 5 ticks have passed since the removal and 5 ticks have passed with presence high.
- R4: With `host_rst`, `vcc_req_n` and `vsel_hi` all high outside a session, `pwr_down` rises after the 3rd tick of that condition (more than 2 ms).
- R5: `pwr_down` clears only when `host_rst` is low. Changes on `vcc_req_n` or `vsel_hi` leave it set.
- R6: On leaving power-down, `status_pd` stays 1 for 6 ticks and falls after the 6th tick if a card is present.
- R7: During power-down, presence keeps being debounced and reported on `status_pd`.
- R8: A session starts when `vcc_req_n` is low while `act_permit` is 1. In a session, removal or any of `flt_ocur`, `flt_uv` or `flt_logic` sets `deact_req` and `status_pd`. Both stay set until `vcc_req_n` returns high.
- R9: `act_permit` is 0 until the 2nd tick after `sup_good` goes high, which guarantees at least 1 ms of good supply. `act_permit` drops as soon as `sup_good` falls.
- R10: `act_permit` is 1 only with supply settled, card present, no power-down, no warm-up hold and no fault input active.
- R11: Fault inputs outside a session have no effect on `status_pd` or `deact_req`. They only clear `act_permit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond enable, synchronous to clk |
| card_pres | input | 1 | Card presence switch, high = card in slot (asynchronous) |
| vcc_req_n | input | 1 | Host activate command, low = activate (asynchronous) |
| host_rst | input | 1 | Host card reset input (asynchronous) |
| vsel_hi | input | 1 | Host voltage select (asynchronous) |
| sup_good | input | 1 | Logic supply good flag (asynchronous) |
| flt_ocur | input | 1 | Card overcurrent flag (asynchronous) |
| flt_uv | input | 1 | Card supply undervoltage flag (asynchronous) |
| flt_logic | input | 1 | Logic supply fault flag (asynchronous) |
| status_pd | output | 1 | Pull-down enable for the open-drain status line, 1 = line low |
| pwr_down | output | 1 | Low-power state active |
| act_permit | output | 1 | Activation allowed |
| deact_req | output | 1 | Deactivation request on a session fault |

## Verification
Every input reaches the first state register through two synchronizer flops. A level change therefore shows on the outputs on the third clock edge. A tick-counted event shows one edge after the tick that completes its count. The bench drives inputs on falling edges and waits four cycles before issuing any tick. It spaces ticks four cycles apart and samples three cycles after the last one, so every result has settled before it is compared. The removal path is also checked at exact cycle offsets: the status is still clear after two edges and set after the third.

// File: rtl/card_status_ctrl.sv
module card_status_ctrl #(
  parameter int DEB_TICKS  = 5,
  parameter int PD_TICKS   = 2,
  parameter int WAKE_TICKS = 6,
  parameter int SUP_TICKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic card_pres,
  input  logic vcc_req_n,
  input  logic host_rst,
  input  logic vsel_hi,
  input  logic sup_good,
  input  logic flt_ocur,
  input  logic flt_uv,
  input  logic flt_logic,
  output logic status_pd,
  output logic pwr_down,
  output logic act_permit,
  output logic deact_req
);

  localparam int M1   = (DEB_TICKS > WAKE_TICKS) ? DEB_TICKS : WAKE_TICKS;
  localparam int M2   = (SUP_TICKS > PD_TICKS + 1) ? SUP_TICKS : PD_TICKS + 1;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXT + 2);
  localparam logic [CW-1:0] DEB_N  = CW'(DEB_TICKS);
  localparam logic [CW-1:0] PD_N   = CW'(PD_TICKS + 1);
  localparam logic [CW-1:0] WAKE_N = CW'(WAKE_TICKS);
  localparam logic [CW-1:0] SUP_N  = CW'(SUP_TICKS);
  localparam logic [7:0]    SYNC_RST = 8'b0000_0010;

  logic [7:0] s1, s2;
  logic pres_s, req_n_s, hrst_s, vsel_s, sup_s, fault_any;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
    end else begin
      s1 <= {flt_logic, flt_uv, flt_ocur, sup_good, vsel_hi, host_rst, vcc_req_n, card_pres};
      s2 <= s1;
    end

  assign pres_s    = s2[0];
  assign req_n_s   = s2[1];
  assign hrst_s    = s2[2];
  assign vsel_s    = s2[3];
  assign sup_s     = s2[4];
  assign fault_any = |s2[7:5];

  logic [CW-1:0] ins_cnt, hold_cnt, sup_cnt, pd_cnt, wake_cnt;
  logic card_ok, in_session, flt_lat;
  logic pd_cond, wake_now, sup_ok;

  assign pd_cond  = hrst_s && req_n_s && vsel_s && !in_session;
  assign wake_now = pwr_down && !hrst_s;
  assign sup_ok   = (sup_cnt == SUP_N);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ins_cnt  <= '0;
      hold_cnt <= '0;
      card_ok  <= 1'b0;
    end else begin
      if (!pres_s)                           ins_cnt <= '0;
      else if (ms_tick && ins_cnt != DEB_N)  ins_cnt <= ins_cnt + 1'b1;
      if (card_ok && !pres_s)                hold_cnt <= DEB_N;
      else if (ms_tick && hold_cnt != '0)    hold_cnt <= hold_cnt - 1'b1;
      card_ok <= pres_s && (ins_cnt == DEB_N) && (hold_cnt == '0);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             sup_cnt <= '0;
    else if (!sup_s)                        sup_cnt <= '0;
    else if (ms_tick && sup_cnt != SUP_N)   sup_cnt <= sup_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_cnt   <= '0;
      pwr_down <= 1'b0;
      wake_cnt <= '0;
    end else begin
      if (!pd_cond || pwr_down)               pd_cnt <= '0;
      else if (ms_tick && pd_cnt != PD_N)     pd_cnt <= pd_cnt + 1'b1;
      if (wake_now)                           pwr_down <= 1'b0;
      else if (pd_cnt == PD_N)                pwr_down <= 1'b1;
      if (wake_now)                           wake_cnt <= WAKE_N;
      else if (ms_tick && wake_cnt != '0)     wake_cnt <= wake_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_session <= 1'b0;
      flt_lat    <= 1'b0;
    end else begin
      if (req_n_s)          in_session <= 1'b0;
      else if (act_permit)  in_session <= 1'b1;
      if (req_n_s)                                     flt_lat <= 1'b0;
      else if (in_session && (fault_any || !pres_s))   flt_lat <= 1'b1;
    end

  assign act_permit = sup_ok && card_ok && !pwr_down && (wake_cnt == '0) && !fault_any;
  assign status_pd  = in_session ? flt_lat : (!card_ok || wake_cnt != '0);
  assign deact_req  = flt_lat;

endmodule

module card_status_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pres_s,
  input logic req_n_s,
  input logic hrst_s,
  input logic vsel_s,
  input logic status_pd,
  input logic pwr_down,
  input logic act_permit,
  input logic deact_req
);

  // R3
  removal_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pres_s) |=> status_pd);

  // R4
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(hrst_s && req_n_s && vsel_s));

  // R5
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !$past(hrst_s));

  // R10
  pd_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !act_permit);

  // R8
  fault_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> status_pd);

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_req && !req_n_s) |=> deact_req);

endmodule

bind card_status_ctrl card_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pres_s(pres_s), .req_n_s(req_n_s),
  .hrst_s(hrst_s), .vsel_s(vsel_s), .status_pd(status_pd),
  .pwr_down(pwr_down), .act_permit(act_permit), .deact_req(deact_req)
);

// File: tb/card_status_ctrl_bench.sv
module card_status_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic card_pres = 1'b0, vcc_req_n = 1'b1, host_rst = 1'b0, vsel_hi = 1'b0;
  logic sup_good = 1'b0, flt_ocur = 1'b0, flt_uv = 1'b0, flt_logic = 1'b0;
  logic status_pd, pwr_down, act_permit, deact_req;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  card_status_ctrl u_card_status_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .card_pres(card_pres),
    .vcc_req_n(vcc_req_n), .host_rst(host_rst), .vsel_hi(vsel_hi),
    .sup_good(sup_good), .flt_ocur(flt_ocur), .flt_uv(flt_uv), .flt_logic(flt_logic),
    .status_pd(status_pd), .pwr_down(pwr_down), .act_permit(act_permit),
    .deact_req(deact_req)
  );

  // {pres, req_n, hrst, vsel, sup}_{ocur,uv,logic}_ticks_{st,pd,perm,deact}_req
  localparam int NV = 32;
  localparam logic [19:0] VEC [NV] = '{
    20'b11001_000_0001_1000_0010, // R2 first tick
    20'b11001_000_0001_1000_1001, // R9 supply settled, no card yet
    20'b11001_000_0010_1000_0010, // R2 four ticks
    20'b11001_000_0001_0010_0010, // R2 fifth tick: present
    20'b10001_000_0000_0010_1010, // R10 session start
    20'b10001_100_0000_1001_1000, // R8 overcurrent
    20'b10001_000_0000_1011_1000, // R8 latched after fault clears
    20'b11001_000_0000_0010_1000, // R8 released by host
    20'b10001_000_0000_0010_1010, // R10 new session
    20'b00001_000_0000_1001_0011, // R3 removal in session
    20'b01001_000_0000_1000_0001, // R1 no card, idle
    20'b11001_000_0100_1000_0011, // R3 bounce back: still low after 4
    20'b11001_000_0001_0010_0011, // R3 released after 5
    20'b11111_000_0010_0010_0100, // R4 two ticks: awake
    20'b11111_000_0001_0100_0100, // R4 third tick: power-down
    20'b01111_000_0000_1100_0111, // R7 removal during power-down
    20'b11111_000_0101_0100_0111, // R7 reinserted and debounced
    20'b10101_000_0000_0100_0101, // R5 activate/vsel ignored
    20'b11011_000_0000_1000_0110, // R6 reset low: wake hold
    20'b11011_000_0101_1000_0110, // R6 five ticks still held
    20'b11011_000_0001_0010_0110, // R6 sixth tick: ready
    20'b11010_000_0000_0000_1001, // R9 supply lost
    20'b11011_000_0001_0000_1001, // R9 one tick not enough
    20'b11011_000_0001_0010_1001, // R9 second tick
    20'b10011_000_0000_0010_1010, // R10 session
    20'b10011_010_0000_1001_1000, // R8 undervoltage
    20'b11011_000_0000_0010_1000, // R8 release
    20'b10011_000_0000_0010_1000, // R8 session
    20'b10011_001_0000_1001_1000, // R8 logic supply fault
    20'b11011_000_0000_0010_1000, // R8 release
    20'b11011_100_0000_0000_1011, // R11 fault outside session
    20'b11011_000_0000_0010_1011  // R11 fault cleared
  };

  task automatic chk(input string what, input int rq, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("reset status", 1, status_pd, 1'b1);
    chk("reset pwr_down", 1, pwr_down, 1'b0);
    chk("reset permit", 1, act_permit, 1'b0);
    chk("reset deact", 1, deact_req, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("idle status", 1, status_pd, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      {card_pres, vcc_req_n, host_rst, vsel_hi, sup_good} = v[19:15];
      {flt_ocur, flt_uv, flt_logic} = v[14:12];
      repeat (4) @(negedge clk);
      tick_n(int'(v[11:8]));
      repeat (3) @(negedge clk);
      chk($sformatf("vec %0d status", i), int'(v[3:0]), status_pd, v[7]);
      chk($sformatf("vec %0d pwr_down", i), int'(v[3:0]), pwr_down, v[6]);
      chk($sformatf("vec %0d permit", i), int'(v[3:0]), act_permit, v[5]);
      chk($sformatf("vec %0d deact", i), int'(v[3:0]), deact_req, v[4]);
    end

    // R3 removal latency: third edge after the change
    card_pres = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("removal after 2 edges", 3, status_pd, 1'b0);
    @(posedge clk); #1;
    chk("removal after 3 edges", 3, status_pd, 1'b1);
    @(negedge clk) card_pres = 1'b1;
    repeat (4) @(negedge clk);
    tick_n(5);
    repeat (3) @(negedge clk);
    chk("reinsert ready", 2, status_pd, 1'b0);

    // R2 short high pulse restarts the debounce
    card_pres = 1'b0;
    repeat (4) @(negedge clk);
    tick_n(5);
    card_pres = 1'b1;
    repeat (4) @(negedge clk);
    tick_n(3);
    card_pres = 1'b0;
    repeat (4) @(negedge clk);
    card_pres = 1'b1;
    repeat (4) @(negedge clk);
    tick_n(4);
    repeat (3) @(negedge clk);
    chk("restarted debounce not done", 2, status_pd, 1'b1);
    tick_n(1);
    repeat (3) @(negedge clk);
    chk("restarted debounce done", 2, status_pd, 1'b0);

    // R1 reset mid-run returns to the reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk("re-reset status", 1, status_pd, 1'b1);
    chk("re-reset permit", 1, act_permit, 1'b0);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule